// File: doc/BRIEF.md
# Interrupt Pin Acceptance and End-of-Interrupt Engine

This block sits between a bank of interrupt request pins and the message fabric of an interrupt routing controller. Every cycle it samples the raw pin levels. It turns each level into an effective request, using the polarity and trigger settings of that pin's routing entry, and decides whether the request becomes a delivery message or is reported as coalesced. Routing entries come from an external register block as one flat, combinationally readable vector. The engine keeps only the per-pin request bits, the queued-service bits and the remote-pending flags. The remote-pending flags are driven out so the register block can show them.

Delivery messages leave through a single valid/ready port. A message holds still while it is stalled. When several pins are queued, the lowest-numbered unmasked pin goes out first, and the others wait in their queued bits. End-of-interrupt notices come in through a second valid/ready port that carries a vector. An accepted notice starts a walk that visits one pin per cycle. Each pin whose entry holds the vector raises an acknowledge pulse. For level-triggered entries the walk also clears the remote-pending flag and may queue a new delivery. No new notice is taken until the walk has finished.

Top module: `irq_accept_engine`

## Requirements
- R1: While reset is asserted and right after it, msg_valid_o, ack_valid_o, coal_o and rpend_o are all zero and eoi_ready_o is one.
- R2: Each routing entry is 23 bits: vector [7:0], destination [15:8], delivery mode [18:16], logical-destination flag [19], active-low flag [20], level-trigger flag [21], mask [22]. The effective level is the pin XOR the active-low flag. The request bit takes the effective level at every clock edge. A 0-to-1 change of the effective level against the request bit is a new request.
- R3: For an edge-triggered entry (bit 21 = 0), a new request is queued unless that pin already has a queued service. If it has one, coal_o for that pin is high for the one cycle after the sampling edge.
- R4: For a level-triggered entry (bit 21 = 1), a new request is queued only if the pin has neither a queued service nor a set remote-pending flag. Otherwise it is reported on coal_o with the timing of R3.
- R5: A masked entry (bit 22 = 1) never produces a message. A queued service whose entry is masked before it is sent is discarded and does not come back when the mask is cleared.
- R6: A sent message carries the entry's vector, destination, logical-destination flag, delivery mode and trigger flag as they were in the cycle the message was loaded, plus the pin index.
- R7: A message for pin 0 always has msg_dest_logical_o = 0 and msg_dest_o = BOOT_DEST, whatever its entry holds.
- R8: The message register loads when it is empty or accepted in the same cycle (msg_ready_i = 1). It takes the lowest-numbered queued, unmasked pin, one pin per cycle, and that pin's queued bit is cleared. While msg_valid_o = 1 and msg_ready_i = 0, the message and all its fields stay unchanged.
- R9: Loading a message for a level-triggered entry sets that pin's rpend_o bit at the same edge.
- R10: A notice is taken at an edge where eoi_valid_i = 1 and eoi_ready_o = 1. eoi_ready_o then stays low for NPINS cycles. In the k-th of those cycles (k from 0), pin k is examined, and ack_valid_o = 1 with ack_pin_o = k exactly when entry k's vector equals the notice vector.
- R11: For a matched level-triggered entry, the walk clears rpend_o for that pin. If the flag was set, the entry is unmasked and the request bit is still 1, it queues a new delivery.
- R12: A matched edge-triggered entry is acknowledged and nothing else about it changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw interrupt pin levels |
| rte_tbl_i | input | NPINS*23 | Routing entries, pin i at bits [i*23 +: 23] |
| msg_valid_o | output | 1 | Delivery message valid |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_pin_o | output | $clog2(NPINS) | Pin that caused the message |
| msg_vector_o | output | 8 | Vector |
| msg_dest_o | output | 8 | Destination ID |
| msg_dest_logical_o | output | 1 | 1 = logical destination mode |
| msg_lvl_trig_o | output | 1 | 1 = level-triggered message |
| msg_dlv_mode_o | output | 3 | Delivery mode |
| coal_o | output | NPINS | One-cycle coalesced-request pulses |
| rpend_o | output | NPINS | Remote-pending flags for the register block |
| eoi_valid_i | input | 1 | End-of-interrupt notice valid |
| eoi_ready_o | output | 1 | Engine can take a notice |
| eoi_vector_i | input | 8 | Vector of the notice |
| ack_valid_o | output | 1 | A pin matched the notice being walked |
| ack_pin_o | output | $clog2(NPINS) | Index of the matching pin |

## Verification
A wrong remote-pending flag shows on rpend_o at the next edge. It also changes whether the following request on that pin comes out as a message or as a coal_o pulse. A lost or duplicated queued bit shows as a missing, extra or out-of-order message one or two cycles after the request, or as soon as back-pressure is released. A walk that is off by one position shows at once as an ack on the wrong pin or in the wrong cycle, and as eoi_ready_o coming back at the wrong time. The bench drives random back-pressure, pin toggles, mask changes and notices, so each of these faults reaches a port within a few cycles of the event that causes it.

// File: rtl/iae_pkg.sv
package iae_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;

  typedef struct packed {
    logic              mask;
    logic              lvl_trig;
    logic              act_low;
    logic              dst_logical;
    logic [DLV_W-1:0]  dlv;
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vec;
  } rte_t;

  localparam int ENT_W = $bits(rte_t);
endpackage

// File: rtl/iae_pin_front.sv
module iae_pin_front #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] act_low_i,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] pend_i,
  input  logic [NPINS-1:0] rpend_i,
  output logic [NPINS-1:0] irr_o,
  output logic [NPINS-1:0] fire_o,
  output logic [NPINS-1:0] coal_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic eff, rise, blocked, req_q, coal_q;

    assign eff     = pin_i[g] ^ act_low_i[g];
    assign rise    = eff & ~req_q;
    assign blocked = pend_i[g] | (lvl_i[g] & rpend_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q  <= 1'b0;
        coal_q <= 1'b0;
      end else begin
        req_q  <= eff;
        coal_q <= rise & blocked;
      end
    end

    assign irr_o[g]  = req_q;
    assign fire_o[g] = rise & ~blocked;
    assign coal_o[g] = coal_q;

    // R3
    coal_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coal_q |-> req_q);
  end
endmodule

// File: rtl/iae_prio_pick.sv
module iae_prio_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_oh_o,
  output logic [IW-1:0] grant_idx_o,
  output logic          grant_vld_o
);
  always_comb begin
    grant_oh_o  = '0;
    grant_idx_o = '0;
    grant_vld_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_oh_o  = '0;
        grant_oh_o[i] = 1'b1;
        grant_idx_o = IW'(i);
        grant_vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iae_eoi_walk.sv
module iae_eoi_walk
  import iae_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid_i,
  input  logic [VEC_W-1:0]       eoi_vector_i,
  output logic                   eoi_ready_o,
  input  logic [NPINS*VEC_W-1:0] vec_tbl_i,
  output logic                   hit_o,
  output logic [PIN_W-1:0]       idx_o
);
  localparam logic [PIN_W-1:0] LAST = PIN_W'(NPINS - 1);

  logic [VEC_W-1:0] vtab [NPINS];
  for (genvar g = 0; g < NPINS; g++) begin : g_vt
    assign vtab[g] = vec_tbl_i[g*VEC_W +: VEC_W];
  end

  logic             busy_q;
  logic [PIN_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
    end else if (!busy_q) begin
      if (eoi_valid_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        vec_q  <= eoi_vector_i;
      end
    end else begin
      if (idx_q == LAST) busy_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign eoi_ready_o = !busy_q;
  assign hit_o       = busy_q && (vtab[idx_q] == vec_q);
  assign idx_o       = idx_q;

  // R10
  eoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid_i && eoi_ready_o |=> !eoi_ready_o && idx_o == '0);
endmodule

// File: rtl/irq_accept_engine.sv
module irq_accept_engine
  import iae_pkg::*;
#(
  parameter int NPINS = 8,
  parameter logic [DEST_W-1:0] BOOT_DEST = '0,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_i,
  input  logic [NPINS*ENT_W-1:0] rte_tbl_i,
  output logic                   msg_valid_o,
  input  logic                   msg_ready_i,
  output logic [PIN_W-1:0]       msg_pin_o,
  output logic [VEC_W-1:0]       msg_vector_o,
  output logic [DEST_W-1:0]      msg_dest_o,
  output logic                   msg_dest_logical_o,
  output logic                   msg_lvl_trig_o,
  output logic [DLV_W-1:0]       msg_dlv_mode_o,
  output logic [NPINS-1:0]       coal_o,
  output logic [NPINS-1:0]       rpend_o,
  input  logic                   eoi_valid_i,
  output logic                   eoi_ready_o,
  input  logic [VEC_W-1:0]       eoi_vector_i,
  output logic                   ack_valid_o,
  output logic [PIN_W-1:0]       ack_pin_o
);
  rte_t                   ent [NPINS];
  logic [NPINS-1:0]       mask_v, lvl_v, pol_v;
  logic [NPINS*VEC_W-1:0] vec_flat;

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    assign ent[g]      = rte_t'(rte_tbl_i[g*ENT_W +: ENT_W]);
    assign mask_v[g]   = ent[g].mask;
    assign lvl_v[g]    = ent[g].lvl_trig;
    assign pol_v[g]    = ent[g].act_low;
    assign vec_flat[g*VEC_W +: VEC_W] = ent[g].vec;
  end

  logic [NPINS-1:0] pend_q, rpend_q, irr, fire;

  iae_pin_front #(.NPINS(NPINS)) u_front (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .act_low_i(pol_v), .lvl_i(lvl_v),
    .pend_i(pend_q), .rpend_i(rpend_q), .irr_o(irr), .fire_o(fire), .coal_o(coal_o)
  );

  logic             scan_hit;
  logic [PIN_W-1:0] scan_idx;

  iae_eoi_walk #(.NPINS(NPINS)) u_walk (
    .clk(clk), .rst_n(rst_n), .eoi_valid_i(eoi_valid_i), .eoi_vector_i(eoi_vector_i),
    .eoi_ready_o(eoi_ready_o), .vec_tbl_i(vec_flat), .hit_o(scan_hit), .idx_o(scan_idx)
  );

  assign ack_valid_o = scan_hit;
  assign ack_pin_o   = scan_idx;

  logic [NPINS-1:0] eoi_clr, eoi_resend;
  always_comb begin
    eoi_clr = '0;
    if (scan_hit && lvl_v[scan_idx]) eoi_clr[scan_idx] = 1'b1;
  end
  assign eoi_resend = eoi_clr & rpend_q & ~mask_v & irr;

  logic [NPINS-1:0] grant_oh;
  logic [PIN_W-1:0] grant_idx;
  logic             grant_vld;

  iae_prio_pick #(.N(NPINS)) u_pick (
    .req_i(pend_q & ~mask_v), .grant_oh_o(grant_oh),
    .grant_idx_o(grant_idx), .grant_vld_o(grant_vld)
  );

  logic             do_load;
  logic [NPINS-1:0] load_oh;
  rte_t             sel;

  assign do_load = grant_vld && (!msg_valid_o || msg_ready_i);
  assign load_oh = do_load ? grant_oh : '0;
  assign sel     = ent[grant_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      rpend_q <= '0;
    end else begin
      pend_q  <= (pend_q | fire | eoi_resend) & ~mask_v & ~load_oh;
      rpend_q <= (rpend_q & ~eoi_clr) | (load_oh & lvl_v);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid_o        <= 1'b0;
      msg_pin_o          <= '0;
      msg_vector_o       <= '0;
      msg_dest_o         <= '0;
      msg_dest_logical_o <= 1'b0;
      msg_lvl_trig_o     <= 1'b0;
      msg_dlv_mode_o     <= '0;
    end else if (do_load) begin
      msg_valid_o    <= 1'b1;
      msg_pin_o      <= grant_idx;
      msg_vector_o   <= sel.vec;
      msg_lvl_trig_o <= sel.lvl_trig;
      msg_dlv_mode_o <= sel.dlv;
      if (grant_idx == '0) begin
        msg_dest_o         <= BOOT_DEST;
        msg_dest_logical_o <= 1'b0;
      end else begin
        msg_dest_o         <= sel.dest;
        msg_dest_logical_o <= sel.dst_logical;
      end
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

  assign rpend_o = rpend_q;

  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_pin_o) &&
      $stable(msg_vector_o) && $stable(msg_dest_o) && $stable(msg_dest_logical_o) &&
      $stable(msg_lvl_trig_o) && $stable(msg_dlv_mode_o));

  // R7
  boot_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && msg_pin_o == '0 |-> !msg_dest_logical_o && msg_dest_o == BOOT_DEST);

  // R8
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (grant_oh & pend_q) != '0);

  // R9
  rpend_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_load && lvl_v[grant_idx] |=> rpend_o[msg_pin_o]);
endmodule

// File: tb/irq_accept_engine_bench.sv
`timescale 1ns/100ps
module irq_accept_engine_bench;
  localparam int NP = 8;
  localparam int EW = 23;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pins = 8'h08;
  logic [NP*EW-1:0] tbl = '0;
  logic            msg_ready = 1'b1;
  logic            eoi_valid = 1'b0;
  logic [7:0]      eoi_vec = '0;

  logic            msg_valid_o, msg_dest_logical_o, msg_lvl_trig_o;
  logic [2:0]      msg_pin_o, ack_pin_o, msg_dlv_mode_o;
  logic [7:0]      msg_vector_o, msg_dest_o;
  logic [NP-1:0]   coal_o, rpend_o;
  logic            eoi_ready_o, ack_valid_o;

  always #2.5 clk = ~clk;

  irq_accept_engine u_irq_accept_engine (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .rte_tbl_i(tbl),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready), .msg_pin_o(msg_pin_o),
    .msg_vector_o(msg_vector_o), .msg_dest_o(msg_dest_o),
    .msg_dest_logical_o(msg_dest_logical_o), .msg_lvl_trig_o(msg_lvl_trig_o),
    .msg_dlv_mode_o(msg_dlv_mode_o), .coal_o(coal_o), .rpend_o(rpend_o),
    .eoi_valid_i(eoi_valid), .eoi_ready_o(eoi_ready_o), .eoi_vector_i(eoi_vec),
    .ack_valid_o(ack_valid_o), .ack_pin_o(ack_pin_o)
  );

  int n_chk = 0, n_err = 0;
  int sent [NP];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [EW-1:0] mk(bit m, bit l, bit p, bit lg, logic [2:0] d,
                                       logic [7:0] dst, logic [7:0] v);
    return {m, l, p, lg, d, dst, v};
  endfunction

  function automatic logic [EW-1:0] ent(int i);
    return tbl[i*EW +: EW];
  endfunction

  // behavioural reference state
  logic [NP-1:0] m_irr, m_pend, m_rp, m_coal;
  logic m_mv, m_mlog, m_mtrig, m_busy;
  logic [2:0] m_mpin, m_mdlv;
  logic [7:0] m_mvec, m_mdest, m_evec;
  int m_idx;

  task automatic model_reset();
    m_irr = '0; m_pend = '0; m_rp = '0; m_coal = '0;
    m_mv = 0; m_mlog = 0; m_mtrig = 0; m_busy = 0;
    m_mpin = '0; m_mdlv = '0; m_mvec = '0; m_mdest = '0; m_evec = '0; m_idx = 0;
  endtask

  task automatic model_step();
    logic [NP-1:0] eff, rise, blk, msk, lvl, eclr, eres, ld;
    logic [EW-1:0] e;
    int g;
    for (int i = 0; i < NP; i++) begin
      e = ent(i);
      msk[i] = e[22]; lvl[i] = e[21];
      eff[i] = pins[i] ^ e[20];
      rise[i] = eff[i] & ~m_irr[i];
      blk[i] = m_pend[i] | (e[21] & m_rp[i]);
    end
    eclr = '0; eres = '0;
    if (m_busy) begin
      e = ent(m_idx);
      if (e[7:0] == m_evec && e[21]) begin
        eclr[m_idx] = 1'b1;
        if (m_rp[m_idx] && !e[22] && m_irr[m_idx]) eres[m_idx] = 1'b1;
      end
    end
    ld = '0;
    if (!m_mv || msg_ready) begin
      g = -1;
      for (int i = NP - 1; i >= 0; i--) if (m_pend[i] && !msk[i]) g = i;
      if (g >= 0) begin
        e = ent(g);
        ld[g] = 1'b1;
        m_mv = 1; m_mpin = 3'(g); m_mvec = e[7:0]; m_mdlv = e[18:16]; m_mtrig = e[21];
        if (g == 0) begin m_mdest = 8'h00; m_mlog = 0; end
        else begin m_mdest = e[15:8]; m_mlog = e[19]; end
      end else m_mv = 0;
    end
    m_pend = (m_pend | (rise & ~blk) | eres) & ~msk & ~ld;
    m_rp   = (m_rp & ~eclr) | (ld & lvl);
    m_coal = rise & blk;
    m_irr  = eff;
    if (!m_busy) begin
      if (eoi_valid) begin m_busy = 1; m_idx = 0; m_evec = eoi_vec; end
    end else begin
      if (m_idx == NP - 1) m_busy = 0;
      m_idx = (m_idx + 1) % NP;
    end
  endtask

  task automatic compare();
    logic exp_ack;
    chk("R8 msg valid", msg_valid_o, m_mv);
    if (m_mv) begin
      chk("R8 msg pin", msg_pin_o, m_mpin);
      chk("R6 vector", msg_vector_o, m_mvec);
      chk("R6 delivery mode", msg_dlv_mode_o, m_mdlv);
      chk("R6 trigger", msg_lvl_trig_o, m_mtrig);
      chk(m_mpin == 0 ? "R7 boot dest" : "R6 dest", msg_dest_o, m_mdest);
      chk(m_mpin == 0 ? "R7 physical mode" : "R6 dest mode", msg_dest_logical_o, m_mlog);
      if (msg_ready) sent[msg_pin_o]++;
    end
    chk("R3 R4 coalesced", coal_o, m_coal);
    chk("R9 R11 R12 remote pending", rpend_o, m_rp);
    chk("R10 eoi ready", eoi_ready_o, !m_busy);
    exp_ack = m_busy && (ent(m_idx) & 23'hFF) == m_evec;
    chk("R10 ack valid", ack_valid_o, exp_ack);
    if (exp_ack) chk("R10 ack pin", ack_pin_o, m_idx);
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset(); else model_step();
    #1;
    if (rst_n) compare();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_eoi(input logic [7:0] v);
    while (!eoi_ready_o) @(negedge clk);
    eoi_valid = 1'b1; eoi_vec = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): got 150000 cycles expected completion");
    finish_run();
  end

  initial begin
    logic [NP-1:0] rp_before;
    int s6;
    for (int i = 0; i < NP; i++) sent[i] = 0;
    tbl[0*EW +: EW] = mk(0, 0, 0, 1, 3'd1, 8'h05, 8'h20);
    tbl[1*EW +: EW] = mk(0, 0, 0, 0, 3'd0, 8'h11, 8'h21);
    tbl[2*EW +: EW] = mk(0, 1, 0, 0, 3'd0, 8'h12, 8'h30);
    tbl[3*EW +: EW] = mk(0, 1, 1, 1, 3'd2, 8'h13, 8'h31);
    tbl[4*EW +: EW] = mk(1, 0, 0, 0, 3'd0, 8'h14, 8'h40);
    tbl[5*EW +: EW] = mk(0, 1, 0, 0, 3'd0, 8'h15, 8'h30);
    tbl[6*EW +: EW] = mk(0, 0, 0, 1, 3'd4, 8'h7F, 8'h50);
    tbl[7*EW +: EW] = mk(1, 1, 0, 0, 3'd0, 8'h17, 8'h51);
    cyc(3);
    // R1 reset state
    chk("R1 msg valid", msg_valid_o, 0);
    chk("R1 ack", ack_valid_o, 0);
    chk("R1 coal", coal_o, 0);
    chk("R1 rpend", rpend_o, 0);
    chk("R1 eoi ready", eoi_ready_o, 1);
    rst_n = 1'b1;
    cyc(3);
    // R8 simultaneous edge pins, lowest first
    pins |= 8'h43; cyc(6); pins &= ~8'h43; cyc(2);
    // R3 repeated edge requests under back-pressure
    msg_ready = 0;
    repeat (3) begin pins |= 8'h02; cyc(1); pins &= ~8'h02; cyc(1); end
    cyc(2); msg_ready = 1; cyc(5);
    // R4 level pin blocked by remote pending
    pins |= 8'h04; cyc(4); pins &= ~8'h04; cyc(1); pins |= 8'h04; cyc(3);
    // R11 EOI clears and re-delivers
    send_eoi(8'h30); cyc(12); pins &= ~8'h04; cyc(2);
    // R2 active-low pin
    pins &= ~8'h08; cyc(5);
    chk("R2 active-low pin delivered once", sent[3], 1);
    send_eoi(8'h31); pins |= 8'h08; cyc(12);
    // R5 masked entries
    pins |= 8'h90; cyc(5);
    chk("R5 masked pin4 silent", sent[4], 0);
    chk("R5 masked pin7 silent", sent[7], 0);
    pins &= ~8'h90; cyc(2);
    s6 = sent[6];
    msg_ready = 0; pins |= 8'h42; cyc(3);
    tbl[6*EW + 22] = 1'b1; cyc(2);
    tbl[6*EW + 22] = 1'b0; msg_ready = 1; cyc(5);
    chk("R5 queued pin6 dropped by mask", sent[6], s6);
    pins &= ~8'h42; cyc(2);
    // R12 EOI on edge vector leaves remote pending alone
    pins |= 8'h04; cyc(4);
    rp_before = rpend_o;
    send_eoi(8'h21); cyc(10);
    chk("R12 rpend untouched by edge EOI", rpend_o, rp_before);
    pins &= ~8'h04; send_eoi(8'h30); cyc(10);
    // random phase
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      msg_ready = ($urandom % 4) != 0;
      if (($urandom % 3) == 0) pins[$urandom % NP] ^= 1'b1;
      if (($urandom % 97) == 0) tbl[($urandom % NP)*EW + 22] ^= 1'b1;
      if (eoi_valid) eoi_valid = 1'b0;
      else if (eoi_ready_o && ($urandom % 6) == 0) begin
        eoi_valid = 1'b1;
        eoi_vec = ent($urandom % NP) & 23'hFF;
      end
    end
    eoi_valid = 1'b0; msg_ready = 1'b1; pins = 8'h08;
    cyc(30);
    finish_run();
  end
endmodule